// File: doc/BRIEF.md
# Serial ADC Read Controller

This block runs the read cycle of a 16-bit serial sampling converter from the host side. A start request raises the convert strobe. The strobe is held high for a programmable conversion time and then dropped. Driving the strobe low enables the converter's data output and opens its sampling phase. The block then clocks the converter with exactly 16 shift-clock pulses, which it derives from the system clock. It captures the serial data line on every rising shift-clock edge, most significant bit first, and presents the assembled word with a one-cycle valid pulse.

The strobe stays low for at least a programmable sample window before it can rise again. In sleep mode the block raises the strobe at the end of that window. The converter then converts and sleeps with the strobe high, so the next start only has to drop the strobe and shift. In auto mode the block starts each new conversion itself as soon as the window closes, which gives a continuous stream of results.

Top module: `adc_read_ctrl`

## Requirements
- R1: While `rst_ni` is low and right after reset, `conv_o`, `sck_o`, `busy_o` and `valid_o` are 0 and `data_o` is 0.
- R2: A start sampled while idle with the strobe low sets `conv_o` at that clock edge. The strobe then stays high for `CONV_CYC` cycles before it falls. No falling edge of the strobe ever follows less than `CONV_CYC` cycles of high level.
- R3: `sck_o` idles low and is never high while `conv_o` is high. Each strobe-low window carries exactly 16 rising edges. Each clock level lasts `CLK_DIV` cycles, and the first rise comes `CLK_DIV` cycles after the strobe falls.
- R4: `data_o` bit 15 holds the bit captured at the first rising edge and bit 0 the bit captured at the 16th. The converter drives its first bit when the strobe falls and each following bit at a falling shift-clock edge. No shift clocks are issued past the 16th.
- R5: `valid_o` is high for exactly one cycle, in the same cycle that `data_o` takes the new word. At all other times `data_o` holds its value. In normal mode `valid_o` rises `CONV_CYC + 31*CLK_DIV` cycles after the edge that accepted the start.
- R6: Once the strobe falls, it stays low for at least `SAMPLE_MIN` cycles, and in any case until one cycle after the last shift-clock fall.
- R7: `busy_o` rises at the edge that accepts a start and stays high until the sample window closes. A start request while `busy_o` is high is ignored: it produces no conversion and no result.
- R8: In sleep mode (`sleep_mode_i`=1) the strobe rises when the window closes. It is held for the conversion and then left high with `busy_o` low. A start in this parked state drops the strobe at the accepting edge, and `valid_o` follows `31*CLK_DIV` cycles later. Clearing sleep mode while parked keeps the prepared conversion for the next read.
- R9: In auto mode (`auto_mode_i`=1) a new conversion starts when each window closes, with no start request. Consecutive `valid_o` pulses are then `CONV_CYC + max(SAMPLE_MIN, 32*CLK_DIV+1)` cycles apart, and this holds whether or not sleep mode is set. Clearing auto mode lets the current read finish, after which the block settles as R8 or normal mode dictates.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Read request, sampled on each clock edge while idle |
| sleep_mode_i | input | 1 | Park the strobe high between reads |
| auto_mode_i | input | 1 | Chain conversions back to back |
| sdo_i | input | 1 | Serial data from the converter |
| conv_o | output | 1 | Convert strobe to the converter |
| sck_o | output | 1 | Shift clock to the converter |
| busy_o | output | 1 | Read cycle in progress |
| data_o | output | 16 | Last assembled conversion result |
| valid_o | output | 1 | One-cycle pulse marking a new result |

## Verification
The bench drives each start just after a falling clock edge, so the accepting edge is the next rising edge. The strobe is therefore sampled high one half-cycle later. The result is due `1 + CONV_CYC + 31*CLK_DIV` counted cycles after the drive from an idle-low state, and `1 + 31*CLK_DIV` from a parked strobe. These totals come from bench functions and are compared against a free-running cycle counter read on falling edges. In auto mode the gap between consecutive valid pulses is checked against the computed period. A port model of the converter times each strobe level and counts the shift-clock rises in each window. It launches every bit on a falling shift-clock edge and queues the random or directed word it converts, and each valid pulse is compared against that queue.

// File: rtl/adc_rd_pkg.sv
package adc_rd_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_CONV  = 2'd1,
    ST_SHIFT = 2'd2,
    ST_HOLD  = 2'd3
  } rd_state_e;
endpackage

// File: rtl/adc_rd_sclk_gen.sv
module adc_rd_sclk_gen #(
  parameter int CLK_DIV = 2,
  parameter int NBITS   = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic sck_o,
  output logic rise_o,
  output logic last_rise_o,
  output logic last_fall_o
);
  localparam int DW = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
  localparam int BW = $clog2(NBITS + 1);

  logic [DW-1:0] div_q;
  logic [BW-1:0] bit_q;
  logic          sck_q;
  logic          tick;

  assign tick        = run_i && (div_q == DW'(CLK_DIV - 1));
  assign rise_o      = tick && !sck_q;
  assign last_rise_o = rise_o && (bit_q == BW'(NBITS - 1));
  assign last_fall_o = tick && sck_q && (bit_q == BW'(NBITS - 1));
  assign sck_o       = sck_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q <= '0;
      bit_q <= '0;
      sck_q <= 1'b0;
    end else if (!run_i) begin
      div_q <= '0;
      bit_q <= '0;
      sck_q <= 1'b0;
    end else if (tick) begin
      div_q <= '0;
      sck_q <= !sck_q;
      if (sck_q) bit_q <= bit_q + 1'b1;
    end else begin
      div_q <= div_q + 1'b1;
    end
  end

  // R3
  bit_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_q <= BW'(NBITS));
endmodule

// File: rtl/adc_rd_shifter.sv
module adc_rd_shifter #(
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              shift_i,
  input  logic              last_i,
  input  logic              sdo_i,
  output logic [DATA_W-1:0] data_o,
  output logic              valid_o
);
  logic [DATA_W-1:0] shreg_q;
  logic [DATA_W-1:0] data_q;
  logic              valid_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shreg_q <= '0;
      data_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= 1'b0;
      if (shift_i) shreg_q <= {shreg_q[DATA_W-2:0], sdo_i};
      if (last_i) begin
        data_q  <= {shreg_q[DATA_W-2:0], sdo_i};
        valid_q <= 1'b1;
      end
    end
  end

  assign data_o  = data_q;
  assign valid_o = valid_q;

  // R5
  valid_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_q |=> !valid_q);
  // R5
  data_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_q |-> $stable(data_q));
endmodule

// File: rtl/adc_rd_seq.sv
module adc_rd_seq
  import adc_rd_pkg::*;
#(
  parameter int CONV_CYC   = 20,
  parameter int SAMPLE_MIN = 80
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic sleep_i,
  input  logic auto_i,
  input  logic bits_done_i,
  output logic conv_o,
  output logic shift_run_o,
  output logic busy_o
);
  localparam int CW = $clog2(CONV_CYC + 1);
  localparam int WW = $clog2(SAMPLE_MIN + 1);

  rd_state_e     state_q;
  logic          conv_q;
  logic          park_q;
  logic [CW-1:0] conv_cnt_q;
  logic [WW-1:0] win_cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      conv_q     <= 1'b0;
      park_q     <= 1'b0;
      conv_cnt_q <= '0;
      win_cnt_q  <= '0;
    end else begin
      if (win_cnt_q != '0) win_cnt_q <= win_cnt_q - 1'b1;
      unique case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            if (conv_q) begin
              // parked: conversion already done, read at once
              conv_q    <= 1'b0;
              win_cnt_q <= WW'(SAMPLE_MIN - 1);
              state_q   <= ST_SHIFT;
            end else begin
              conv_q     <= 1'b1;
              park_q     <= 1'b0;
              conv_cnt_q <= CW'(CONV_CYC - 1);
              state_q    <= ST_CONV;
            end
          end
        end
        ST_CONV: begin
          if (conv_cnt_q == '0) begin
            if (park_q) begin
              state_q <= ST_IDLE;
            end else begin
              conv_q    <= 1'b0;
              win_cnt_q <= WW'(SAMPLE_MIN - 1);
              state_q   <= ST_SHIFT;
            end
          end else begin
            conv_cnt_q <= conv_cnt_q - 1'b1;
          end
        end
        ST_SHIFT: begin
          if (bits_done_i) state_q <= ST_HOLD;
        end
        ST_HOLD: begin
          if (win_cnt_q == '0) begin
            if (auto_i || sleep_i) begin
              conv_q     <= 1'b1;
              park_q     <= !auto_i;
              conv_cnt_q <= CW'(CONV_CYC - 1);
              state_q    <= ST_CONV;
            end else begin
              state_q <= ST_IDLE;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign conv_o      = conv_q;
  assign shift_run_o = (state_q == ST_SHIFT);
  assign busy_o      = (state_q != ST_IDLE);

  // level-duration monitors for the strobe timing checks
  logic [CW-1:0] hi_run_q;
  logic [WW-1:0] lo_run_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_run_q <= '0;
      lo_run_q <= WW'(SAMPLE_MIN);
    end else begin
      if (!conv_q) hi_run_q <= '0;
      else if (hi_run_q != CW'(CONV_CYC)) hi_run_q <= hi_run_q + 1'b1;
      if (conv_q) lo_run_q <= '0;
      else if (lo_run_q != WW'(SAMPLE_MIN)) lo_run_q <= lo_run_q + 1'b1;
    end
  end

  // R2
  conv_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(conv_q) |-> hi_run_q == CW'(CONV_CYC));
  // R6
  sample_win_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(conv_q) |-> lo_run_q == WW'(SAMPLE_MIN));
  // R7
  start_accept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && !busy_o |=> busy_o);
endmodule

// File: rtl/adc_read_ctrl.sv
module adc_read_ctrl #(
  parameter int DATA_W     = 16,
  parameter int CLK_DIV    = 2,
  parameter int CONV_CYC   = 20,
  parameter int SAMPLE_MIN = 80
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              sleep_mode_i,
  input  logic              auto_mode_i,
  input  logic              sdo_i,
  output logic              conv_o,
  output logic              sck_o,
  output logic              busy_o,
  output logic [DATA_W-1:0] data_o,
  output logic              valid_o
);
  localparam int RW = $clog2(DATA_W + 1) + 1;

  logic shift_run;
  logic bit_rise;
  logic last_rise;
  logic last_fall;

  adc_rd_seq #(
    .CONV_CYC  (CONV_CYC),
    .SAMPLE_MIN(SAMPLE_MIN)
  ) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .sleep_i    (sleep_mode_i),
    .auto_i     (auto_mode_i),
    .bits_done_i(last_fall),
    .conv_o     (conv_o),
    .shift_run_o(shift_run),
    .busy_o     (busy_o)
  );

  adc_rd_sclk_gen #(
    .CLK_DIV(CLK_DIV),
    .NBITS  (DATA_W)
  ) u_sclk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .run_i      (shift_run),
    .sck_o      (sck_o),
    .rise_o     (bit_rise),
    .last_rise_o(last_rise),
    .last_fall_o(last_fall)
  );

  adc_rd_shifter #(
    .DATA_W(DATA_W)
  ) u_shift (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .shift_i(bit_rise),
    .last_i (last_rise),
    .sdo_i  (sdo_i),
    .data_o (data_o),
    .valid_o(valid_o)
  );

  // shift-clock rise count within the current strobe-low window
  logic          sck_d_q;
  logic [RW-1:0] rise_cnt_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sck_d_q    <= 1'b0;
      rise_cnt_q <= '0;
    end else begin
      sck_d_q <= sck_o;
      if (conv_o) rise_cnt_q <= '0;
      else if (sck_o && !sck_d_q) rise_cnt_q <= rise_cnt_q + 1'b1;
    end
  end

  // R3
  sck_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (conv_o || !busy_o) |-> !sck_o);
  // R3
  rise_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_cnt_q <= RW'(DATA_W));
  // R4
  bit_count_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> $rose(sck_o) && rise_cnt_q == RW'(DATA_W - 1));
endmodule

// File: tb/adc_read_ctrl_tb.sv
module adc_read_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int W          = 16;
  localparam int CLK_DIV    = 2;
  localparam int CONV_CYC   = 20;
  localparam int SAMPLE_MIN = 80;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic sleep_m = 1'b0;
  logic auto_m = 1'b0;
  logic sdo = 1'b0;
  logic conv, sck, busy, valid;
  logic [W-1:0] data;

  always #(CLK_PERIOD / 2) clk = ~clk;

  adc_read_ctrl #(
    .DATA_W(W), .CLK_DIV(CLK_DIV), .CONV_CYC(CONV_CYC), .SAMPLE_MIN(SAMPLE_MIN)
  ) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .sleep_mode_i(sleep_m),
    .auto_mode_i(auto_m), .sdo_i(sdo), .conv_o(conv), .sck_o(sck),
    .busy_o(busy), .data_o(data), .valid_o(valid)
  );

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic int lat_idle();
    return 1 + CONV_CYC + 31 * CLK_DIV;
  endfunction
  function automatic int lat_parked();
    return 1 + 31 * CLK_DIV;
  endfunction
  function automatic int auto_period();
    int win = (SAMPLE_MIN > 32 * CLK_DIV + 1) ? SAMPLE_MIN : 32 * CLK_DIV + 1;
    return CONV_CYC + win;
  endfunction

  // converter port model
  logic [W-1:0] exp_q[$];
  logic [W-1:0] cur_word = '0;
  int word_n = 0;
  int hi_len = 0;
  int lo_len = 1000;
  int bidx = 0;
  int rise_cnt = 0;
  logic conv_p = 1'b0;
  logic sck_p = 1'b0;

  function automatic logic [W-1:0] next_word(input int n);
    case (n)
      0: return 16'h0000;
      1: return 16'hFFFF;
      2: return 16'h8000;
      3: return 16'h0001;
      4: return 16'hA5C3;
      default: return W'($urandom);
    endcase
  endfunction

  always @(negedge clk) begin
    if (rst_n) begin
      if (conv && !conv_p) begin
        // R6
        chk(lo_len >= SAMPLE_MIN, "R6 strobe low time", lo_len, SAMPLE_MIN);
        // R3 exactly 16 clocks in the window just closed
        if (rise_cnt != 0) chk(rise_cnt == W, "R3 sck rises per window", rise_cnt, W);
        rise_cnt = 0;
        cur_word = next_word(word_n);
        word_n++;
        exp_q.push_back(cur_word);
        hi_len = 1;
      end else if (!conv && conv_p) begin
        // R2
        chk(hi_len >= CONV_CYC, "R2 strobe high time", hi_len, CONV_CYC);
        lo_len = 1;
        bidx = 0;
        sdo <= cur_word[W-1];
      end else if (conv) begin
        hi_len++;
      end else begin
        lo_len++;
      end
      if (sck && !sck_p) begin
        rise_cnt++;
        if (conv) chk(1'b0, "R3 sck high with strobe high", 1, 0);
      end
      if (!sck && sck_p && !conv) begin
        bidx++;
        sdo <= (bidx < W) ? cur_word[W-1-bidx] : 1'b0;
      end
    end
    conv_p = conv;
    sck_p = sck;
  end

  // result monitor
  int n_valid = 0;
  int valid_cyc = 0;
  logic valid_p = 1'b0;
  always @(negedge clk) begin
    if (rst_n && valid) begin
      // R5
      chk(!valid_p, "R5 valid width", 2, 1);
      if (exp_q.size() == 0) begin
        chk(1'b0, "R4 unexpected result", data, 0);
      end else begin
        logic [W-1:0] e;
        e = exp_q.pop_front();
        // R4
        chk(data == e, "R4 data word", data, e);
      end
      n_valid++;
      valid_cyc = cyc;
    end
    valid_p = valid;
  end

  task automatic step();
    @(negedge clk);
    #1;
  endtask

  task automatic pulse_start(output int c0);
    c0 = cyc;
    start = 1'b1;
    step();
    start = 1'b0;
  endtask

  task automatic wait_valid(output int vc);
    int n0 = n_valid;
    vc = -1;
    for (int i = 0; i < 3000; i++) begin
      if (n_valid != n0) begin
        vc = valid_cyc;
        break;
      end
      step();
    end
    if (vc < 0) chk(1'b0, "R5 result timeout", 0, 1);
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 3000 && busy; i++) step();
    step();
  endtask

  initial begin
    int c0, vc, vprev, nv;
    void'($urandom(32'd20240611));
    repeat (4) step();
    // R1
    chk(conv == 1'b0, "R1 reset conv", conv, 0);
    chk(sck == 1'b0, "R1 reset sck", sck, 0);
    chk(busy == 1'b0, "R1 reset busy", busy, 0);
    chk(valid == 1'b0, "R1 reset valid", valid, 0);
    chk(data == '0, "R1 reset data", data, 0);
    rst_n = 1'b1;
    step();
    chk(conv == 1'b0 && busy == 1'b0, "R1 after reset", {conv, busy}, 0);

    // normal mode reads with random gaps
    for (int i = 0; i < 8; i++) begin
      repeat ($urandom_range(0, 15)) step();
      pulse_start(c0);
      // R2 R7
      chk(conv == 1'b1, "R2 strobe raised", conv, 1);
      chk(busy == 1'b1, "R7 busy raised", busy, 1);
      wait_valid(vc);
      // R5
      chk(vc - c0 == lat_idle(), "R5 normal latency", vc - c0, lat_idle());
      wait_idle();
    end

    // R7 start while busy is ignored
    pulse_start(c0);
    repeat (30) step();
    pulse_start(vc);
    wait_valid(vc);
    chk(vc - c0 == lat_idle(), "R7 latency with extra start", vc - c0, lat_idle());
    wait_idle();
    nv = n_valid;
    repeat (300) step();
    chk(n_valid == nv, "R7 no result from ignored start", n_valid, nv);
    chk(conv == 1'b0 && busy == 1'b0, "R7 idle after ignored start", {conv, busy}, 0);

    // R8 sleep mode
    sleep_m = 1'b1;
    pulse_start(c0);
    wait_valid(vc);
    chk(vc - c0 == lat_idle(), "R8 first sleep-mode read", vc - c0, lat_idle());
    wait_idle();
    chk(conv == 1'b1, "R8 strobe parked high", conv, 1);
    for (int i = 0; i < 6; i++) begin
      repeat ($urandom_range(0, 40)) step();
      chk(conv == 1'b1 && busy == 1'b0, "R8 parked idle", {conv, busy}, 2'b10);
      pulse_start(c0);
      chk(conv == 1'b0, "R8 strobe dropped on start", conv, 0);
      wait_valid(vc);
      chk(vc - c0 == lat_parked(), "R8 parked latency", vc - c0, lat_parked());
      wait_idle();
    end
    // R8 leaving sleep mode keeps the prepared conversion
    sleep_m = 1'b0;
    step();
    pulse_start(c0);
    wait_valid(vc);
    chk(vc - c0 == lat_parked(), "R8 read after sleep cleared", vc - c0, lat_parked());
    wait_idle();
    chk(conv == 1'b0, "R8 strobe low after sleep cleared", conv, 0);

    // R9 auto mode, without then with sleep mode
    for (int s = 0; s < 2; s++) begin
      sleep_m = (s == 1);
      auto_m = 1'b1;
      pulse_start(c0);
      wait_valid(vprev);
      chk(vprev - c0 == lat_idle(), "R9 first auto latency", vprev - c0, lat_idle());
      for (int k = 0; k < 6; k++) begin
        wait_valid(vc);
        chk(vc - vprev == auto_period(), "R9 auto period", vc - vprev, auto_period());
        vprev = vc;
      end
      auto_m = 1'b0;
      wait_idle();
      nv = n_valid;
      repeat (200) step();
      chk(n_valid == nv, "R9 stream stops after auto cleared", n_valid, nv);
      chk(conv == (s == 1), "R9 settle state after auto", conv, (s == 1));
      if (s == 1) begin
        sleep_m = 1'b0;
        pulse_start(c0);
        wait_valid(vc);
        chk(vc - c0 == lat_parked(), "R8 read after auto in sleep", vc - c0, lat_parked());
        wait_idle();
      end
    end

    repeat (20) step();
    chk(exp_q.size() == 0, "R4 all conversions read", exp_q.size(), 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "watchdog expired", 0, 1);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule